// File: doc/BRIEF.md
# Credit-Bounded Request/Reply Network Endpoint

This block is one node's attachment point to a two-channel interconnect carrying a shared-address-space protocol. On the outgoing side, a local command port issues remote reads and writes. Each issued request takes one of `CREDITS` transaction tags. Each tag owns a reply slot, so the answer to every request already has room waiting before the request leaves. The incoming reply channel has no ready signal: replies are never refused or dropped. Each reply lands in its slot and is handed to the local completion port. The credit is returned when that completion is taken.

On the incoming side, requests from the other `NODES-1` nodes enter a single arrival-order queue of `CREDITS*(NODES-1)` entries. Per-source counters cap each node at `CREDITS` waiting entries, so one busy neighbour can never use another node's share. A server state machine takes the oldest entry and spends `MEM_LAT` cycles on a local word memory. It then presents the reply on a separate outgoing reply channel. Because replies and requests use separate channels, back-pressure on one never stalls the other.

The server state machine has three states. SRV_IDLE moves to SRV_ACCESS when a request is waiting; the request is popped on that transition. SRV_ACCESS counts `MEM_LAT` cycles, performs the memory read or write in its last cycle, then moves to SRV_REPLY. SRV_REPLY holds the reply until it is accepted, then returns to SRV_IDLE.

Top module: `rr_endpoint`

## Requirements
- R1: After reset, no tag is outstanding: `cmd_ready` equals `rqo_ready`, while `rpo_valid` and `cpl_valid` are low.
- R2: At most `CREDITS` requests are outstanding. While all tags are held, `cmd_ready` and `rqo_valid` stay low.
- R3: An issued request carries the lowest-numbered free tag, and the command's write flag, destination, address and data, unchanged. Write flag 1 means write.
- R4: A reply is always accepted and fills the slot named by its tag. Full slots are presented on the completion port lowest tag first, with the reply's write flag and data.
- R5: A tag's credit returns in the cycle its completion is consumed (`cpl_valid && cpl_ready`). A filled but unconsumed slot still holds its credit.
- R6: Each source node has at most `CREDITS` requests waiting. `rqi_ready` is low for a source that has reached the limit, and other sources are unaffected.
- R7: Requests that claim this node's own ID (`SELF_ID`) are refused.
- R8: Incoming requests are served in arrival order across all sources. A read returns the addressed memory word (the memory resets to zero). A write stores its data and returns an acknowledgement with write flag 1 and data 0. The reply is addressed to the requesting node and carries its tag.
- R9: When no request is waiting or in service, `rpo_valid` is low.
- R10: A reply held by back-pressure keeps `rpo_valid` and its fields stable. Incoming replies and completions keep flowing while the request and reply channels are stalled.
- R11: A reply with no matching outstanding tag, or a per-source count above `CREDITS`, is a protocol violation. In legal traffic, every credit is back once all completions are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Local command present |
| cmd_ready | output | 1 | Command taken this cycle if valid |
| cmd_write | input | 1 | 1 = remote write, 0 = remote read |
| cmd_dest | input | NODE_W | Target node |
| cmd_addr | input | ADDR_W | Remote word address |
| cmd_wdata | input | DATA_W | Write data |
| cpl_valid | output | 1 | A completed reply is available |
| cpl_ready | input | 1 | Local side takes the completion |
| cpl_tag | output | TAG_W | Tag of the completion |
| cpl_write | output | 1 | Completion is a write acknowledgement |
| cpl_data | output | DATA_W | Read data of the completion |
| rqo_valid | output | 1 | Outgoing request valid |
| rqo_ready | input | 1 | Network accepts the outgoing request |
| rqo_src | output | NODE_W | This node's ID |
| rqo_dest | output | NODE_W | Destination of the request |
| rqo_tag | output | TAG_W | Transaction tag |
| rqo_write | output | 1 | Request kind |
| rqo_addr | output | ADDR_W | Word address |
| rqo_data | output | DATA_W | Write data |
| rpi_valid | input | 1 | Incoming reply (always accepted) |
| rpi_tag | input | TAG_W | Tag of the incoming reply |
| rpi_write | input | 1 | Reply is a write acknowledgement |
| rpi_data | input | DATA_W | Reply data |
| rqi_valid | input | 1 | Incoming request valid |
| rqi_ready | output | 1 | Incoming request accepted |
| rqi_src | input | NODE_W | Requesting node |
| rqi_tag | input | TAG_W | Requester's tag |
| rqi_write | input | 1 | Request kind |
| rqi_addr | input | ADDR_W | Local word address |
| rqi_data | input | DATA_W | Write data |
| rpo_valid | output | 1 | Outgoing reply valid |
| rpo_ready | input | 1 | Network accepts the outgoing reply |
| rpo_dest | output | NODE_W | Requesting node the reply goes to |
| rpo_tag | output | TAG_W | Requester's tag echoed |
| rpo_write | output | 1 | Write acknowledgement flag |
| rpo_data | output | DATA_W | Read data, or 0 for a write |

## Verification
The bench builds the block with four nodes, two credits, node 0 as itself, a 32-word memory and a two-cycle access. The inbound queue therefore has six entries, which is not a power of two, so pointer wrap is exercised. Two credits are few enough that one source fills its share within a handful of requests. The same holds for outgoing tags: the credit stall and lowest-tag-first completion both occur within a few commands, and the tag field is a single bit. While the reply output is stalled, reply slots are filled and drained to show that the two directions are independent. A later mix of sources then checks global arrival order against memory contents.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        SRV_IDLE   = 2'd0,
        SRV_ACCESS = 2'd1,
        SRV_REPLY  = 2'd2
    } srv_state_e;
endpackage

// File: rtl/rr_credit_tracker.sv
module rr_credit_tracker #(
    parameter int CREDITS = 2,
    parameter int TAG_W   = 1,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    output logic              have_credit,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              rsp_write,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic              cpl_write,
    output logic [DATA_W-1:0] cpl_data,
    output logic [CREDITS-1:0] slot_busy,
    output logic [CREDITS-1:0] slot_full
);
    logic [DATA_W-1:0] slot_data [CREDITS];
    logic [CREDITS-1:0] slot_wr;

    always_comb begin
        alloc_tag   = '0;
        have_credit = 1'b0;
        for (int i = CREDITS - 1; i >= 0; i--) begin
            if (!slot_busy[i]) begin
                alloc_tag   = TAG_W'(i);
                have_credit = 1'b1;
            end
        end
    end

    always_comb begin
        cpl_tag   = '0;
        cpl_valid = 1'b0;
        for (int i = CREDITS - 1; i >= 0; i--) begin
            if (slot_full[i]) begin
                cpl_tag   = TAG_W'(i);
                cpl_valid = 1'b1;
            end
        end
    end

    assign cpl_write = slot_wr[cpl_tag];
    assign cpl_data  = slot_data[cpl_tag];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_busy <= '0;
            slot_full <= '0;
            slot_wr   <= '0;
        end else begin
            if (issue) begin
                slot_busy[alloc_tag] <= 1'b1;
            end
            if (rsp_valid) begin
                slot_full[rsp_tag] <= 1'b1;
                slot_wr[rsp_tag]   <= rsp_write;
            end
            if (cpl_valid && cpl_ready) begin
                slot_busy[cpl_tag] <= 1'b0;
                slot_full[cpl_tag] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rsp_valid) begin
            slot_data[rsp_tag] <= rsp_data;
        end
    end
endmodule

// File: rtl/rr_req_queue.sv
module rr_req_queue #(
    parameter int NODES   = 4,
    parameter int CREDITS = 2,
    parameter int SELF_ID = 0,
    parameter int NODE_W  = 2,
    parameter int ENT_W   = 25,
    parameter int CNT_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [ENT_W-1:0]       in_entry,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic [ENT_W-1:0]       out_entry,
    input  logic                   pop,
    output logic [NODES*CNT_W-1:0] src_cnt_flat
);
    localparam int DEPTH = CREDITS * (NODES - 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;
    logic [CNT_W-1:0] src_cnt [NODES];
    logic [NODE_W-1:0] in_src, pop_src;
    logic src_ok, push;

    assign in_src  = in_entry[ENT_W-1 -: NODE_W];
    assign pop_src = out_entry[ENT_W-1 -: NODE_W];
    assign src_ok  = ({1'b0, in_src} < (NODE_W + 1)'(NODES)) && (in_src != NODE_W'(SELF_ID));
    assign in_ready  = src_ok && (src_cnt[in_src] < CNT_W'(CREDITS));
    assign push      = in_valid && in_ready;
    assign out_valid = (occ != '0);
    assign out_entry = store[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            for (int n = 0; n < NODES; n++) src_cnt[n] <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
            for (int n = 0; n < NODES; n++) begin
                src_cnt[n] <= src_cnt[n]
                            + CNT_W'(push && (in_src == NODE_W'(n)))
                            - CNT_W'(pop && (pop_src == NODE_W'(n)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= in_entry;
    end

    generate
        for (genvar g = 0; g < NODES; g++) begin : g_cnt
            assign src_cnt_flat[g*CNT_W +: CNT_W] = src_cnt[g];
        end
    endgenerate
endmodule

// File: rtl/rr_mem_server.sv
module rr_mem_server
    import rr_pkg::*;
#(
    parameter int NODE_W  = 2,
    parameter int TAG_W   = 1,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int MEM_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [NODE_W-1:0] q_src,
    input  logic [TAG_W-1:0]  q_tag,
    input  logic              q_write,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [DATA_W-1:0] q_data,
    output logic              q_pop,
    output logic              rpo_valid,
    input  logic              rpo_ready,
    output logic [NODE_W-1:0] rpo_dest,
    output logic [TAG_W-1:0]  rpo_tag,
    output logic              rpo_write,
    output logic [DATA_W-1:0] rpo_data
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int LAT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;

    srv_state_e state, state_nx;
    logic [LAT_W-1:0]  lat_cnt;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [DATA_W-1:0] mem [WORDS];
    logic              last_beat;

    assign last_beat = (lat_cnt == LAT_W'(MEM_LAT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SRV_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SRV_IDLE:   if (q_valid)   state_nx = SRV_ACCESS;
            SRV_ACCESS: if (last_beat) state_nx = SRV_REPLY;
            SRV_REPLY:  if (rpo_ready) state_nx = SRV_IDLE;
            default:                   state_nx = SRV_IDLE;
        endcase
    end

    always_comb begin
        q_pop     = 1'b0;
        rpo_valid = 1'b0;
        unique case (state)
            SRV_IDLE:   q_pop     = q_valid;
            SRV_ACCESS: ;
            SRV_REPLY:  rpo_valid = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt   <= '0;
            rpo_dest  <= '0;
            rpo_tag   <= '0;
            rpo_write <= 1'b0;
            rpo_data  <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            if (state == SRV_IDLE && q_valid) begin
                lat_cnt   <= '0;
                rpo_dest  <= q_src;
                rpo_tag   <= q_tag;
                rpo_write <= q_write;
                cur_addr  <= q_addr;
                cur_wdata <= q_data;
            end else if (state == SRV_ACCESS) begin
                lat_cnt <= lat_cnt + 1'b1;
                if (last_beat) begin
                    if (rpo_write) begin
                        mem[cur_addr] <= cur_wdata;
                        rpo_data      <= '0;
                    end else begin
                        rpo_data <= mem[cur_addr];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rr_endpoint.sv
module rr_endpoint #(
    parameter int NODES   = 4,
    parameter int CREDITS = 2,
    parameter int SELF_ID = 0,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int MEM_LAT = 2,
    localparam int NODE_W = $clog2(NODES),
    localparam int TAG_W  = (CREDITS > 1) ? $clog2(CREDITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [NODE_W-1:0] cmd_dest,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic              cpl_write,
    output logic [DATA_W-1:0] cpl_data,
    output logic              rqo_valid,
    input  logic              rqo_ready,
    output logic [NODE_W-1:0] rqo_src,
    output logic [NODE_W-1:0] rqo_dest,
    output logic [TAG_W-1:0]  rqo_tag,
    output logic              rqo_write,
    output logic [ADDR_W-1:0] rqo_addr,
    output logic [DATA_W-1:0] rqo_data,
    input  logic              rpi_valid,
    input  logic [TAG_W-1:0]  rpi_tag,
    input  logic              rpi_write,
    input  logic [DATA_W-1:0] rpi_data,
    input  logic              rqi_valid,
    output logic              rqi_ready,
    input  logic [NODE_W-1:0] rqi_src,
    input  logic [TAG_W-1:0]  rqi_tag,
    input  logic              rqi_write,
    input  logic [ADDR_W-1:0] rqi_addr,
    input  logic [DATA_W-1:0] rqi_data,
    output logic              rpo_valid,
    input  logic              rpo_ready,
    output logic [NODE_W-1:0] rpo_dest,
    output logic [TAG_W-1:0]  rpo_tag,
    output logic              rpo_write,
    output logic [DATA_W-1:0] rpo_data
);
    localparam int ENT_W = NODE_W + TAG_W + 1 + ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(CREDITS + 1);

    typedef struct packed {
        logic [NODE_W-1:0] src;
        logic [TAG_W-1:0]  tag;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } inreq_t;

    logic              have_credit, issue;
    logic [TAG_W-1:0]  alloc_tag;
    logic [CREDITS-1:0] slot_busy, slot_full;
    logic [NODES*CNT_W-1:0] src_cnt_flat;
    inreq_t            in_ent, head_ent;
    logic              head_valid, head_pop;

    assign rqo_valid = cmd_valid && have_credit;
    assign cmd_ready = rqo_ready && have_credit;
    assign issue     = rqo_valid && rqo_ready;
    assign rqo_src   = NODE_W'(SELF_ID);
    assign rqo_dest  = cmd_dest;
    assign rqo_tag   = alloc_tag;
    assign rqo_write = cmd_write;
    assign rqo_addr  = cmd_addr;
    assign rqo_data  = cmd_wdata;

    rr_credit_tracker #(
        .CREDITS (CREDITS),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .have_credit (have_credit),
        .alloc_tag   (alloc_tag),
        .rsp_valid   (rpi_valid),
        .rsp_tag     (rpi_tag),
        .rsp_write   (rpi_write),
        .rsp_data    (rpi_data),
        .cpl_valid   (cpl_valid),
        .cpl_ready   (cpl_ready),
        .cpl_tag     (cpl_tag),
        .cpl_write   (cpl_write),
        .cpl_data    (cpl_data),
        .slot_busy   (slot_busy),
        .slot_full   (slot_full)
    );

    assign in_ent = '{src: rqi_src, tag: rqi_tag, write: rqi_write,
                      addr: rqi_addr, data: rqi_data};

    rr_req_queue #(
        .NODES   (NODES),
        .CREDITS (CREDITS),
        .SELF_ID (SELF_ID),
        .NODE_W  (NODE_W),
        .ENT_W   (ENT_W),
        .CNT_W   (CNT_W)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rqi_valid),
        .in_entry     (in_ent),
        .in_ready     (rqi_ready),
        .out_valid    (head_valid),
        .out_entry    (head_ent),
        .pop          (head_pop),
        .src_cnt_flat (src_cnt_flat)
    );

    rr_mem_server #(
        .NODE_W  (NODE_W),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MEM_LAT (MEM_LAT)
    ) u_server (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (head_valid),
        .q_src     (head_ent.src),
        .q_tag     (head_ent.tag),
        .q_write   (head_ent.write),
        .q_addr    (head_ent.addr),
        .q_data    (head_ent.data),
        .q_pop     (head_pop),
        .rpo_valid (rpo_valid),
        .rpo_ready (rpo_ready),
        .rpo_dest  (rpo_dest),
        .rpo_tag   (rpo_tag),
        .rpo_write (rpo_write),
        .rpo_data  (rpo_data)
    );
endmodule

// File: rtl/rr_endpoint_chk.sv
module rr_endpoint_chk #(
    parameter int NODES   = 4,
    parameter int CREDITS = 2,
    parameter int DATA_W  = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int TAG_W  = (CREDITS > 1) ? $clog2(CREDITS) : 1,
    localparam int CNT_W  = $clog2(CREDITS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rqo_valid,
    input logic                   rqo_ready,
    input logic [TAG_W-1:0]       rqo_tag,
    input logic                   rpi_valid,
    input logic [TAG_W-1:0]       rpi_tag,
    input logic                   cpl_valid,
    input logic                   cpl_ready,
    input logic [TAG_W-1:0]       cpl_tag,
    input logic                   rpo_valid,
    input logic                   rpo_ready,
    input logic [DATA_W-1:0]      rpo_data,
    input logic [NODE_W-1:0]      rpo_dest,
    input logic [CREDITS-1:0]     slot_busy,
    input logic [CREDITS-1:0]     slot_full,
    input logic [NODES*CNT_W-1:0] src_cnt_flat
);
    // R2
    credit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rqo_valid |-> ($countones(slot_busy) < CREDITS));

    // R3
    free_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rqo_valid && rqo_ready) |-> !slot_busy[rqo_tag]);

    // R11
    matched_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpi_valid |-> (slot_busy[rpi_tag] && !slot_full[rpi_tag]));

    // R5
    credit_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> !slot_busy[$past(cpl_tag)]);

    // R10
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpo_valid && !rpo_ready) |=> (rpo_valid && $stable(rpo_data) && $stable(rpo_dest)));

    generate
        for (genvar g = 0; g < NODES; g++) begin : g_src
            // R6
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                src_cnt_flat[g*CNT_W +: CNT_W] <= CNT_W'(CREDITS));
        end
    endgenerate
endmodule

bind rr_endpoint rr_endpoint_chk #(
    .NODES   (NODES),
    .CREDITS (CREDITS),
    .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/rr_endpoint_bench.sv
module rr_endpoint_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4, CREDITS = 2, SELF_ID = 0;
    localparam int ADDR_W = 5, DATA_W = 16, MEM_LAT = 2;
    localparam int NODE_W = 2, TAG_W = 1;
    localparam int RPW = NODE_W + TAG_W + 1 + DATA_W;
    localparam int CPW = TAG_W + 1 + DATA_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_ready, cmd_write = 0;
    logic [NODE_W-1:0] cmd_dest = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic cpl_valid, cpl_ready = 0, cpl_write;
    logic [TAG_W-1:0] cpl_tag;
    logic [DATA_W-1:0] cpl_data;
    logic rqo_valid, rqo_ready = 1, rqo_write;
    logic [NODE_W-1:0] rqo_src, rqo_dest;
    logic [TAG_W-1:0] rqo_tag;
    logic [ADDR_W-1:0] rqo_addr;
    logic [DATA_W-1:0] rqo_data;
    logic rpi_valid = 0, rpi_write = 0;
    logic [TAG_W-1:0] rpi_tag = '0;
    logic [DATA_W-1:0] rpi_data = '0;
    logic rqi_valid = 0, rqi_ready, rqi_write = 0;
    logic [NODE_W-1:0] rqi_src = '0;
    logic [TAG_W-1:0] rqi_tag = '0;
    logic [ADDR_W-1:0] rqi_addr = '0;
    logic [DATA_W-1:0] rqi_data = '0;
    logic rpo_valid, rpo_ready = 1, rpo_write;
    logic [NODE_W-1:0] rpo_dest;
    logic [TAG_W-1:0] rpo_tag;
    logic [DATA_W-1:0] rpo_data;

    int checks = 0, fails = 0;
    logic [RPW-1:0] exp_rpo [$];
    logic [CPW-1:0] exp_cpl [$];
    logic [DATA_W-1:0] model [1 << ADDR_W];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rr_endpoint #(
        .NODES(NODES), .CREDITS(CREDITS), .SELF_ID(SELF_ID),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)
    ) u_rr_endpoint (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // scoreboard monitors
    always @(negedge clk) begin
        if (rst_n && rpo_valid && rpo_ready) begin
            if (exp_rpo.size() == 0) check(0, "R8 unexpected reply", {rpo_dest, rpo_tag, rpo_write, rpo_data}, 0);
            else begin
                logic [RPW-1:0] e;
                e = exp_rpo.pop_front();
                check({rpo_dest, rpo_tag, rpo_write, rpo_data} == e, "R8 reply", {rpo_dest, rpo_tag, rpo_write, rpo_data}, e);
            end
        end
        if (rst_n && cpl_valid && cpl_ready) begin
            if (exp_cpl.size() == 0) check(0, "R4 unexpected completion", {cpl_tag, cpl_write, cpl_data}, 0);
            else begin
                logic [CPW-1:0] e;
                e = exp_cpl.pop_front();
                check({cpl_tag, cpl_write, cpl_data} == e, "R4 completion", {cpl_tag, cpl_write, cpl_data}, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_req(input logic [NODE_W-1:0] s, input logic [TAG_W-1:0] t, input logic w,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        tick();
        rqi_valid = 1; rqi_src = s; rqi_tag = t; rqi_write = w; rqi_addr = a; rqi_data = d;
        do @(negedge clk); while (!rqi_ready);
        exp_rpo.push_back({s, t, w, w ? 16'h0 : model[a]});
        if (w) model[a] = d;
        tick();
        rqi_valid = 0;
    endtask

    task automatic send_rsp(input logic [TAG_W-1:0] t, input logic w, input logic [DATA_W-1:0] d);
        tick();
        rpi_valid = 1; rpi_tag = t; rpi_write = w; rpi_data = d;
        tick();
        rpi_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        check(rpo_valid == 1'b0 && cpl_valid == 1'b0, "R1 outputs idle", {rpo_valid, cpl_valid}, 0);
        // R9 no request waiting
        check(rpo_valid == 1'b0, "R9 idle reply", rpo_valid, 0);

        // Inbound with reply channel stalled
        tick(); rpo_ready = 0;
        send_req(2'd1, 1'b0, 1'b1, 5'd4, 16'h1111);
        send_req(2'd1, 1'b1, 1'b0, 5'd4, 16'h0);
        send_req(2'd1, 1'b0, 1'b0, 5'd5, 16'h0);
        repeat (6) tick();
        rqi_src = 2'd1;
        @(negedge clk);
        check(rqi_ready == 1'b0, "R6 source at limit", rqi_ready, 0);
        tick(); rqi_src = 2'd2;
        @(negedge clk);
        check(rqi_ready == 1'b1, "R6 other source free", rqi_ready, 1);
        tick(); rqi_src = 2'd0;
        @(negedge clk);
        check(rqi_ready == 1'b0, "R7 own id refused", rqi_ready, 0);
        send_req(2'd2, 1'b1, 1'b1, 5'd5, 16'h2222);
        send_req(2'd2, 1'b0, 1'b0, 5'd5, 16'h0);

        // Outbound credits while inbound side is stalled
        tick();
        cmd_valid = 1; cmd_write = 1; cmd_dest = 2'd2; cmd_addr = 5'd3; cmd_wdata = 16'h00AA;
        @(negedge clk);
        check(rqo_valid && rqo_tag == 1'b0, "R3 first tag", {rqo_valid, rqo_tag}, 2'b10);
        check({rqo_write, rqo_dest, rqo_addr, rqo_data} == {1'b1, 2'd2, 5'd3, 16'h00AA}, "R3 fields",
              {rqo_write, rqo_dest, rqo_addr, rqo_data}, {1'b1, 2'd2, 5'd3, 16'h00AA});
        tick();
        cmd_write = 0; cmd_dest = 2'd3; cmd_addr = 5'd9;
        @(negedge clk);
        check(rqo_valid && rqo_tag == 1'b1, "R3 second tag", {rqo_valid, rqo_tag}, 2'b11);
        tick();
        @(negedge clk);
        check(cmd_ready == 1'b0 && rqo_valid == 1'b0, "R2 credits exhausted", {cmd_ready, rqo_valid}, 0);
        tick(); cmd_valid = 0;

        exp_cpl.push_back({1'b1, 1'b0, 16'h1234});
        send_rsp(1'b1, 1'b0, 16'h1234);
        @(negedge clk);
        check(cpl_valid && cpl_tag == 1'b1 && cpl_data == 16'h1234, "R4 slot filled",
              {cpl_valid, cpl_tag, cpl_data}, {2'b11, 16'h1234});
        check(cmd_ready == 1'b0, "R5 credit held until consumed", cmd_ready, 0);
        check(rpo_valid == 1'b1, "R10 reply held under stall", rpo_valid, 1);
        tick(); cpl_ready = 1;
        tick();
        @(negedge clk);
        check(cmd_ready == 1'b1 && cpl_valid == 1'b0, "R5 credit returned", {cmd_ready, cpl_valid}, 2'b10);
        exp_cpl.push_back({1'b0, 1'b1, 16'h0});
        send_rsp(1'b0, 1'b1, 16'h0);
        repeat (3) tick();

        // Release the reply channel
        rpo_ready = 1;
        for (int i = 0; i < 200 && exp_rpo.size() != 0; i++) tick();
        check(exp_rpo.size() == 0, "R8 all replies in order", exp_rpo.size(), 0);
        repeat (2) tick();
        @(negedge clk);
        check(rpo_valid == 1'b0, "R9 idle after drain", rpo_valid, 0);

        // Lowest tag completes first
        cpl_ready = 0;
        tick(); cmd_valid = 1; cmd_write = 0; cmd_addr = 5'd1;
        tick(); tick(); cmd_valid = 0;
        exp_cpl.push_back({1'b0, 1'b0, 16'hCAFE});
        exp_cpl.push_back({1'b1, 1'b0, 16'hBEEF});
        send_rsp(1'b1, 1'b0, 16'hBEEF);
        send_rsp(1'b0, 1'b0, 16'hCAFE);
        @(negedge clk);
        check(cpl_valid && cpl_tag == 1'b0, "R4 lowest tag first", {cpl_valid, cpl_tag}, 2'b10);
        tick(); cpl_ready = 1;
        repeat (4) tick();
        check(exp_cpl.size() == 0, "R4 completions drained", exp_cpl.size(), 0);

        // Mixed sources, arrival order
        send_req(2'd3, 1'b0, 1'b1, 5'd7, 16'h7777);
        send_req(2'd1, 1'b1, 1'b0, 5'd7, 16'h0);
        send_req(2'd2, 1'b0, 1'b0, 5'd4, 16'h0);
        for (int i = 0; i < 100 && exp_rpo.size() != 0; i++) tick();
        check(exp_rpo.size() == 0, "R8 mixed sources", exp_rpo.size(), 0);
        @(negedge clk);
        check(cmd_ready == 1'b1 && cpl_valid == 1'b0, "R11 all credits back", {cmd_ready, cpl_valid}, 2'b10);

        summary();
        $finish;
    end
endmodule